// File: doc/BRIEF.md
# Line Latch with Alternating Polarity Output Control

This block sits between the capture stage of a column driver and its analog output stage. It holds the most recently captured line of gray codes and presents, for every channel, a drive descriptor: the 6-bit code, a polarity bit choosing the upper or lower reference set, a high-impedance flag and a low-power mode bit. A strobe moves the captured line into the block. The strobe then keeps all outputs floating while it is high, and releases the new line onto the outputs when it falls.

The polarity input sets how odd and even channels alternate. Neighbouring channels always take opposite reference sets. The polarity value is taken with the line on the strobe's rising edge, so later changes wait for the next line. A built-in timing monitor counts clocks. It reports a strobe pulse that is too short, a strobe that follows the last data clock too closely, and a strobe that arrives with no new data since the previous one.

Channel numbers in this brief are 1-based. Channel number c is carried at index c-1 of every per-channel vector. Flat code vectors carry channel index k in bits [6k+5:6k].

Top module: `lld_line_latch`

## Requirements
- R1: After reset, every hiz_o bit is 1, code_o and pol_o are all zero, and err_o is zero. This holds until the first strobe falls.
- R2: On the clock edge where strobe_i is first sampled high, line_i is captured. The outputs keep their old codes while the strobe stays high. On the edge where the strobe is first sampled low again, code_o takes the captured line.
- R3: Every hiz_o bit is 1 from the first edge that samples strobe_i high until the edge that first samples it low. At that falling edge every hiz_o bit returns to 0.
- R4: A pol_o bit of 1 selects the upper reference set and 0 selects the lower set. If pol_i was 0 at capture, odd channel numbers (even indices) get 1 and even channel numbers get 0. If pol_i was 1, the pattern is swapped.
- R5: Changes to pol_i or line_i after the capturing edge have no effect on the line released at the following strobe fall.
- R6: code_o and pol_o keep their values on every edge other than a strobe fall, whatever line_i, pol_i and lowpwr_i do.
- R7: Every lp_o bit equals the lowpwr_i value sampled at the previous clock edge. 1 means reduced-bias mode and 0 means normal mode.
- R8: If the strobe is sampled high on fewer than MIN_HI (default 2) consecutive edges, err_o[0] is 1 for one cycle after the falling edge. The line is still transferred.
- R9: If the strobe rises fewer than MIN_GAP (default 2) clocks after the last edge that sampled load_i high, err_o[1] is 1 for one cycle after the rising edge.
- R10: If the strobe rises with no load_i sample since the previous rise (or since reset), err_o[2] is 1 for one cycle after the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Line transfer strobe |
| pol_i | input | 1 | Polarity select, sampled at strobe rise |
| lowpwr_i | input | 1 | Low-power mode request (1 = reduced bias) |
| load_i | input | 1 | Data clock marker from the capture stage |
| line_i | input | NUM_CH*6 | Captured line of gray codes |
| code_o | output | NUM_CH*6 | Per-channel driven code |
| pol_o | output | NUM_CH | Per-channel reference set (1 = upper) |
| hiz_o | output | NUM_CH | Per-channel high-impedance flag |
| lp_o | output | NUM_CH | Per-channel low-power mode bit |
| err_o | output | 3 | Timing flags: [0] short pulse, [1] early strobe, [2] missing data |

## Verification
A wrong edge detector shows up one cycle late. It leaves hiz_o asserted past the sampled fall, or releases codes early while the strobe is still high. A capture register loaded on the wrong edge shows up only at the next release, as a code or polarity pattern that follows inputs changed after the rise. Counter faults in the timing monitor appear as a missing or extra error pulse in the cycle right after the offending rise or fall.

// File: rtl/lld_pkg.sv
// Package: shared widths and the timing-flag layout for the line latch.
// Assumes one 6-bit code per channel.
package lld_pkg;
    localparam int CODE_W = 6;

    // Timing flags; bit order is visible on err_o
    typedef struct packed {
        logic no_data;    // err_o[2]
        logic early;      // err_o[1]
        logic short_hi;   // err_o[0]
    } lld_err_t;
endpackage

// File: rtl/lld_strobe_ctrl.sv
// Strobe control: detects strobe edges in the clock domain and produces
// the floating flag. Assumes strobe_i is already synchronous to clk.
module lld_strobe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o,
    output logic fall_o,
    output logic float_o
);
    logic strobe_q;

    // Previous strobe sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    assign rise_o = strobe_i & ~strobe_q;
    assign fall_o = ~strobe_i & strobe_q;

    // Outputs float while the strobe is high and are released at its fall
    always_ff @(posedge clk) begin
        if (!rst_n)        float_o <= 1'b1;
        else if (strobe_i) float_o <= 1'b1;
        else if (fall_o)   float_o <= 1'b0;
    end
endmodule

// File: rtl/lld_line_store.sv
// Line store: two-stage per-channel storage. The capture stage loads at
// strobe rise and the drive stage loads at strobe fall. Adjacent channels get
// opposite reference sets. Assumes rise_i and fall_i are never high together.
module lld_line_store
    import lld_pkg::*;
#(
    parameter int NUM_CH = 480,
    localparam int LINE_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              pol_i,
    input  logic [LINE_W-1:0] line_i,
    output logic [LINE_W-1:0] code_o,
    output logic [NUM_CH-1:0] pol_o
);
    logic cap_pol;

    // Polarity value belonging to the captured line
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_pol <= 1'b0;
        else if (rise_i) cap_pol <= pol_i;
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam logic ODD_NUM = ((k % 2) == 0);
        logic [CODE_W-1:0] cap_code;
        logic [CODE_W-1:0] drv_code;
        logic              drv_pol;

        // Capture at rise, release at fall
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_code <= '0;
                drv_code <= '0;
                drv_pol  <= 1'b0;
            end else begin
                if (rise_i) cap_code <= line_i[k*CODE_W +: CODE_W];
                if (fall_i) begin
                    drv_code <= cap_code;
                    drv_pol  <= cap_pol ^ ODD_NUM;
                end
            end
        end

        assign code_o[k*CODE_W +: CODE_W] = drv_code;
        assign pol_o[k] = drv_pol;
    end
endmodule

// File: rtl/lld_strobe_timing.sv
// Strobe timing monitor: counts strobe high samples and the clocks since the
// last data clock, and pulses a flag for each rule broken. Counters saturate
// at their limits. Assumes MIN_HI and MIN_GAP are at least 1.
module lld_strobe_timing
    import lld_pkg::*;
#(
    parameter int MIN_HI  = 2,
    parameter int MIN_GAP = 2,
    localparam int HIW = $clog2(MIN_HI + 1),
    localparam int GPW = $clog2(MIN_GAP + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strobe_i,
    input  logic     rise_i,
    input  logic     fall_i,
    input  logic     load_i,
    output lld_err_t err_o
);
    localparam logic [HIW-1:0] HI_LIM  = HIW'(MIN_HI);
    localparam logic [GPW-1:0] GAP_LIM = GPW'(MIN_GAP);
    localparam logic [GPW-1:0] GAP_OK  = GPW'(MIN_GAP - 1);

    logic [HIW-1:0] hi_cnt;
    logic [GPW-1:0] since_load;
    logic           seen_load;
    lld_err_t       err_d;

    // Number of consecutive high strobe samples
    always_ff @(posedge clk) begin
        if (!rst_n)                           hi_cnt <= '0;
        else if (rise_i)                      hi_cnt <= HIW'(1);
        else if (strobe_i && hi_cnt < HI_LIM) hi_cnt <= hi_cnt + 1'b1;
    end

    // Clocks elapsed since the last data clock
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_load <= GAP_LIM;
        else if (load_i)               since_load <= '0;
        else if (since_load < GAP_LIM) since_load <= since_load + 1'b1;
    end

    // Whether data arrived since the previous strobe rise
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_load <= 1'b0;
        else if (rise_i) seen_load <= 1'b0;
        else if (load_i) seen_load <= 1'b1;
    end

    // Violation decode for this edge
    always_comb begin
        err_d.short_hi = fall_i && (hi_cnt < HI_LIM);
        err_d.early    = rise_i && (load_i || since_load < GAP_OK);
        err_d.no_data  = rise_i && !seen_load && !load_i;
    end

    // One-cycle flag pulses
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= '0;
        else        err_o <= err_d;
    end
endmodule

// File: rtl/lld_line_latch.sv
// Line latch top: joins strobe control, line storage and the timing
// monitor, and fans the floating flag and low-power bit out to every channel.
module lld_line_latch
    import lld_pkg::*;
#(
    parameter int NUM_CH  = 480,
    parameter int MIN_HI  = 2,
    parameter int MIN_GAP = 2,
    localparam int LINE_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              pol_i,
    input  logic              lowpwr_i,
    input  logic              load_i,
    input  logic [LINE_W-1:0] line_i,
    output logic [LINE_W-1:0] code_o,
    output logic [NUM_CH-1:0] pol_o,
    output logic [NUM_CH-1:0] hiz_o,
    output logic [NUM_CH-1:0] lp_o,
    output logic [2:0]        err_o
);
    logic     rise, fall, float_q, lp_q;
    lld_err_t err;

    lld_strobe_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i),
        .rise_o(rise), .fall_o(fall), .float_o(float_q)
    );

    lld_line_store #(.NUM_CH(NUM_CH)) u_store (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
        .pol_i(pol_i), .line_i(line_i), .code_o(code_o), .pol_o(pol_o)
    );

    lld_strobe_timing #(.MIN_HI(MIN_HI), .MIN_GAP(MIN_GAP)) u_timing (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .rise_i(rise),
        .fall_i(fall), .load_i(load_i), .err_o(err)
    );

    // Registered low-power mode request
    always_ff @(posedge clk) begin
        if (!rst_n) lp_q <= 1'b0;
        else        lp_q <= lowpwr_i;
    end

    assign hiz_o = {NUM_CH{float_q}};
    assign lp_o  = {NUM_CH{lp_q}};
    assign err_o = err;
endmodule

// File: rtl/lld_line_latch_chk.sv
// Checker for lld_line_latch: port-level properties of transfer, floating,
// polarity alternation, hold, low-power pass-through and timing flags.
// Assumes NUM_CH >= 2.
module lld_line_latch_chk #(
    parameter int NUM_CH  = 480,
    parameter int MIN_HI  = 2,
    parameter int MIN_GAP = 2,
    localparam int LINE_W = NUM_CH * 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_i,
    input logic              lowpwr_i,
    input logic              load_i,
    input logic [LINE_W-1:0] code_o,
    input logic [NUM_CH-1:0] pol_o,
    input logic [NUM_CH-1:0] hiz_o,
    input logic [NUM_CH-1:0] lp_o,
    input logic [2:0]        err_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (&hiz_o && code_o == '0 && pol_o == '0 && err_o == '0));

    // R3
    float_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> &hiz_o);

    // R3
    release_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe_i) && !strobe_i) |=> (hiz_o == '0));

    // R4
    pol_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hiz_o[0] |-> (pol_o[0] != pol_o[1]));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(strobe_i) && !strobe_i) |=> ($stable(code_o) && $stable(pol_o)));

    // R7
    lowpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lp_o == {NUM_CH{$past(lowpwr_i)}}));

    if (MIN_HI >= 2) begin : g_hi
        // R8
        short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!strobe_i && $past(strobe_i) && !$past(strobe_i, 2)) |=> err_o[0]);
    end

    if (MIN_GAP >= 2) begin : g_gap
        // R9
        early_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe_i && !$past(strobe_i) && $past(load_i)) |=> err_o[1]);
    end
endmodule

bind lld_line_latch lld_line_latch_chk #(
    .NUM_CH(NUM_CH), .MIN_HI(MIN_HI), .MIN_GAP(MIN_GAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .lowpwr_i(lowpwr_i),
    .load_i(load_i), .code_o(code_o), .pol_o(pol_o), .hiz_o(hiz_o),
    .lp_o(lp_o), .err_o(err_o)
);

// File: tb/lld_line_latch_tb.sv
// Directed bench for lld_line_latch with eight channels.
module lld_line_latch_tb;
    localparam int NCH = 8;
    localparam int LW  = NCH * 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_i = 1'b0, pol_i = 1'b0, lowpwr_i = 1'b0, load_i = 1'b0;
    logic [LW-1:0] line_i = '0;
    logic [LW-1:0] code_o;
    logic [NCH-1:0] pol_o, hiz_o, lp_o;
    logic [2:0]    err_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    lld_line_latch #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .pol_i(pol_i),
        .lowpwr_i(lowpwr_i), .load_i(load_i), .line_i(line_i),
        .code_o(code_o), .pol_o(pol_o), .hiz_o(hiz_o), .lp_o(lp_o), .err_o(err_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] mk_line(input int seed);
        logic [LW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*6 +: 6] = 6'((k * 7 + seed) & 63);
        return v;
    endfunction

    // Odd channel numbers (even indices) take the upper set when polarity is 0
    function automatic logic [NCH-1:0] exp_pol(input logic p);
        logic [NCH-1:0] v;
        for (int k = 0; k < NCH; k++) v[k] = ((k % 2) == 0) ? ~p : p;
        return v;
    endfunction

    task automatic feed_load();
        load_i = 1'b1; @(negedge clk);
        load_i = 1'b0; @(negedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_line(input logic [LW-1:0] ln, input logic p, input int hi);
        line_i = ln; pol_i = p; strobe_i = 1'b1;
        repeat (hi) @(negedge clk);
        strobe_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 hiz", LW'(hiz_o), LW'({NCH{1'b1}}));
        chk("R1 code", code_o, '0);
        chk("R1 pol", LW'(pol_o), '0);
        chk("R1 err", LW'(err_o), '0);
    endtask

    task automatic t_transfer();
        feed_load();
        line_i = mk_line(3); pol_i = 1'b0; strobe_i = 1'b1;
        @(negedge clk);
        chk("R3 hiz while high", LW'(hiz_o), LW'({NCH{1'b1}}));
        chk("R2 old code while high", code_o, '0);
        @(negedge clk);
        strobe_i = 1'b0;
        @(negedge clk);
        chk("R2 code after fall", code_o, mk_line(3));
        chk("R3 hiz after fall", LW'(hiz_o), '0);
        chk("R4 pol=0 pattern", LW'(pol_o), LW'(exp_pol(1'b0)));
        chk("R8 R9 R10 no err", LW'(err_o), '0);
    endtask

    task automatic t_pol_swap();
        feed_load();
        strobe_line(mk_line(11), 1'b1, 3);
        chk("R4 pol=1 pattern", LW'(pol_o), LW'(exp_pol(1'b1)));
        chk("R2 second line", code_o, mk_line(11));
    endtask

    task automatic t_late_change();
        feed_load();
        line_i = mk_line(20); pol_i = 1'b0; strobe_i = 1'b1;
        @(negedge clk);
        line_i = mk_line(40); pol_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
        @(negedge clk);
        chk("R5 code ignores late line", code_o, mk_line(20));
        chk("R5 pol ignores late change", LW'(pol_o), LW'(exp_pol(1'b0)));
    endtask

    task automatic t_hold();
        line_i = mk_line(55); pol_i = 1'b1; lowpwr_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 code held", code_o, mk_line(20));
        chk("R6 pol held", LW'(pol_o), LW'(exp_pol(1'b0)));
        chk("R7 lp high", LW'(lp_o), LW'({NCH{1'b1}}));
        lowpwr_i = 1'b0;
        @(negedge clk);
        chk("R7 lp low", LW'(lp_o), '0);
    endtask

    task automatic t_short();
        feed_load();
        strobe_line(mk_line(9), 1'b0, 1);
        chk("R8 short pulse flag", LW'(err_o), LW'(3'b001));
        chk("R8 line still moves", code_o, mk_line(9));
        @(negedge clk);
        chk("R8 flag one cycle", LW'(err_o), '0);
    endtask

    task automatic t_early();
        load_i = 1'b1; @(negedge clk);
        load_i = 1'b0;
        line_i = mk_line(30); strobe_i = 1'b1;
        @(negedge clk);
        chk("R9 early strobe flag", LW'(err_o), LW'(3'b010));
        @(negedge clk);
        strobe_i = 1'b0;
        @(negedge clk);
        chk("R9 flag cleared", LW'(err_o), '0);
    endtask

    task automatic t_nodata();
        repeat (3) @(negedge clk);
        line_i = mk_line(44); strobe_i = 1'b1;
        @(negedge clk);
        chk("R10 no data flag", LW'(err_o), LW'(3'b100));
        @(negedge clk);
        strobe_i = 1'b0;
        @(negedge clk);
        chk("R10 flag cleared", LW'(err_o), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_transfer();
        t_pol_swap();
        t_late_change();
        t_hold();
        t_short();
        t_early();
        t_nodata();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule